// File: doc/BRIEF.md
# Camera Parallel-Port JPEG Frame Capture

This block sits between an 8-bit parallel camera port and a byte-wide buffer memory. The port has a pixel clock, a frame sync line, a line-valid line and a data byte. The block captures the bytes of one compressed frame into the buffer. All four camera inputs are brought into the system clock domain through two-flop synchronisers. The pixel clock is oversampled, and each of its falling edges gives a one-cycle sample strobe. The sensor changes data on the rising edge, so the byte is stable when the falling edge arrives.

Software raises `arm`. The next rising edge of the frame sync line then opens a capture and resets the write address to zero. Storage is enabled immediately at that point, even though the line-valid signal may still be low. As a result, a few leading bytes can be stored ahead of the real image. After that, the line-valid line controls storage: its rising edge enables it and its falling edge disables it.

The capture ends in one of two ways: the frame sync line falls, or the buffer fills. Whichever comes first gives a single done pulse. The stored byte count, a buffer-full flag and a start-of-image flag stay readable after the frame. The start-of-image flag is set only when the first two stored bytes are 0xFF followed by 0xD8. Once a capture has finished, further frames are ignored until `arm` has been taken low and raised again.

Top module: `cam_frame_capture`

## Requirements
- R1: Each falling edge of `cam_pclk` while storage is enabled writes the `cam_data` value present at that edge to the buffer: `mem_we` pulses for one cycle with `mem_wdata` equal to that byte. A raw input change reaches `mem_we` after three rising edges of `clk`.
- R2: A rising edge of `cam_vsync` seen while `arm` is high and the block is idle starts a capture. `busy` goes high, and the first stored byte goes to address 0.
- R3: Storage is enabled at the frame-sync rising edge regardless of `cam_href`, so bytes clocked in while `cam_href` is still low at the start of the frame are stored.
- R4: Within a capture, a falling edge of `cam_href` disables storage: pixel clock edges that follow write nothing. A rising edge of `cam_href` enables storage again.
- R5: A falling edge of `cam_vsync` during a capture ends it. `busy` drops and `done` is high for exactly one cycle.
- R6: When the stored count reaches DEPTH, the capture stops with `buf_full` high and a one-cycle `done`. Later bytes and the later frame-sync fall write nothing and give no further `done`. `byte_count` never exceeds DEPTH.
- R7: `soi_ok` is high only when the bytes stored at addresses 0 and 1 of the current capture are 0xFF and 0xD8 in that order. It is cleared when a new capture starts.
- R8: `byte_count` equals the number of bytes stored in the current capture. Each write uses address `byte_count` taken before the write.
- R9: A frame whose sync rising edge arrives while `arm` is low stores nothing and leaves the status unchanged.
- R10: After a capture finishes, frames are ignored while `arm` stays high. A new capture needs `arm` low for at least one cycle and then high again before the next sync rising edge.
- R11: After reset: `mem_we`, `done`, `busy`, `buf_full` and `soi_ok` are low, and `byte_count` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the camera port |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Enables capture of the next frame |
| cam_pclk | input | 1 | Camera pixel clock |
| cam_vsync | input | 1 | Frame sync, high for the duration of a frame |
| cam_href | input | 1 | Line valid, high while bytes are meaningful |
| cam_data | input | 8 | Camera data byte |
| mem_we | output | 1 | Buffer write strobe |
| mem_addr | output | $clog2(DEPTH) | Buffer write address |
| mem_wdata | output | 8 | Buffer write data |
| busy | output | 1 | Capture in progress |
| done | output | 1 | One-cycle pulse at end of capture |
| byte_count | output | $clog2(DEPTH+1) | Bytes stored in this capture |
| buf_full | output | 1 | Capture stopped because the buffer filled |
| soi_ok | output | 1 | Buffer starts with 0xFF 0xD8 |

## Verification
The bench targets four corner cases:

- **Leading bytes before line-valid.** The frame opens, and bytes are clocked in before `cam_href` rises. A design that waits for line-valid would report a smaller count. It would also wrongly flag a good start-of-image, because the leading bytes should have displaced the marker.
- **Gap in line-valid.** Bytes are clocked during a low period of `cam_href` in the middle of a frame. A design that ignored the line gating would store them and shift every later address.
- **Overrun.** A frame longer than the buffer is sent. This catches a design that wraps the address, overruns the count, or gives a second `done` on the later sync fall.
- **Re-arm gating.** A frame is sent with `arm` still held high after `done`. A design that re-armed by level rather than by a fresh request would overwrite the finished capture.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

  // Capture controller states.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_HOLD = 2'd2
  } cap_state_e;

  // Synchronised camera port; the three control lines sit above the byte.
  typedef struct packed {
    logic       vsync;
    logic       href;
    logic       pclk;
    logic [7:0] data;
  } cam_bus_t;

  localparam int CAM_BUS_W = 11;
  localparam int LINE_VS   = 2;
  localparam int LINE_HR   = 1;
  localparam int LINE_PC   = 0;

endpackage

// File: rtl/cfc_sync.sv
module cfc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;

endmodule

// File: rtl/cfc_edge.sv
module cfc_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    assign rise[i] = lvl[i] & ~prev_q[i];
    assign fall[i] = ~lvl[i] & prev_q[i];
  end

endmodule

// File: rtl/cfc_ctrl.sv
module cfc_ctrl
  import cfc_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          vs_rise,
  input  logic          vs_fall,
  input  logic          hr_rise,
  input  logic          hr_fall,
  input  logic          px_strobe,
  input  logic [7:0]    px_byte,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] byte_count,
  output logic          buf_full,
  output logic          soi_ok
);

  localparam logic [CW-1:0] LAST_IDX = CW'(DEPTH - 1);

  cap_state_e    state_q, state_n;
  logic          gate_q, gate_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          we_q, we_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [7:0]    wd_q, wd_n;
  logic          done_q, done_n;
  logic          full_q, full_n;
  logic          b0_q, b0_n;
  logic          b1_q, b1_n;
  logic          store;

  assign store = (state_q == ST_CAPT) && gate_q && px_strobe;

  always_comb begin
    state_n = state_q;
    gate_n  = gate_q;
    cnt_n   = cnt_q;
    we_n    = 1'b0;
    addr_n  = addr_q;
    wd_n    = wd_q;
    done_n  = 1'b0;
    full_n  = full_q;
    b0_n    = b0_q;
    b1_n    = b1_q;
    unique case (state_q)
      ST_IDLE: begin
        if (vs_rise && arm) begin
          state_n = ST_CAPT;
          gate_n  = 1'b1;
          cnt_n   = '0;
          full_n  = 1'b0;
          b0_n    = 1'b0;
          b1_n    = 1'b0;
        end
      end
      ST_CAPT: begin
        if (hr_rise) gate_n = 1'b1;
        if (hr_fall) gate_n = 1'b0;
        if (store) begin
          we_n   = 1'b1;
          addr_n = cnt_q[AW-1:0];
          wd_n   = px_byte;
          cnt_n  = cnt_q + 1'b1;
          if (cnt_q == CW'(0)) b0_n = (px_byte == 8'hFF);
          if (cnt_q == CW'(1)) b1_n = (px_byte == 8'hD8);
          if (cnt_q == LAST_IDX) begin
            full_n  = 1'b1;
            done_n  = 1'b1;
            state_n = ST_HOLD;
          end
        end
        if (vs_fall && (state_n == ST_CAPT)) begin
          done_n  = 1'b1;
          state_n = ST_HOLD;
        end
        if (state_n != ST_CAPT) gate_n = 1'b0;
      end
      ST_HOLD: begin
        if (!arm) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gate_q  <= 1'b0;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      full_q  <= 1'b0;
      b0_q    <= 1'b0;
      b1_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      gate_q  <= gate_n;
      cnt_q   <= cnt_n;
      we_q    <= we_n;
      done_q  <= done_n;
      full_q  <= full_n;
      b0_q    <= b0_n;
      b1_q    <= b1_n;
    end
  end

  // Write bus registers load only on a store.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wd_q   <= '0;
    end else if (we_n) begin
      addr_q <= addr_n;
      wd_q   <= wd_n;
    end
  end

  assign mem_we     = we_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wd_q;
  assign busy       = (state_q == ST_CAPT);
  assign done       = done_q;
  assign byte_count = cnt_q;
  assign buf_full   = full_q;
  assign soi_ok     = b0_q & b1_q;

endmodule

// File: rtl/cam_frame_capture.sv
module cam_frame_capture
  import cfc_pkg::*;
#(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          cam_pclk,
  input  logic          cam_vsync,
  input  logic          cam_href,
  input  logic [7:0]    cam_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] byte_count,
  output logic          buf_full,
  output logic          soi_ok
);

  cam_bus_t raw_bus, sync_bus;
  logic [2:0] lines;
  logic [2:0] line_rise, line_fall;
  logic       pclk_rise_unused;

  assign raw_bus.vsync = cam_vsync;
  assign raw_bus.href  = cam_href;
  assign raw_bus.pclk  = cam_pclk;
  assign raw_bus.data  = cam_data;

  cfc_sync #(.W(CAM_BUS_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_bus),
    .d_sync  (sync_bus)
  );

  assign lines[LINE_VS] = sync_bus.vsync;
  assign lines[LINE_HR] = sync_bus.href;
  assign lines[LINE_PC] = sync_bus.pclk;

  cfc_edge #(.W(3)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (lines),
    .rise  (line_rise),
    .fall  (line_fall)
  );

  assign pclk_rise_unused = line_rise[LINE_PC];

  cfc_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .vs_rise    (line_rise[LINE_VS]),
    .vs_fall    (line_fall[LINE_VS]),
    .hr_rise    (line_rise[LINE_HR]),
    .hr_fall    (line_fall[LINE_HR]),
    .px_strobe  (line_fall[LINE_PC]),
    .px_byte    (sync_bus.data),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .busy       (busy),
    .done       (done),
    .byte_count (byte_count),
    .buf_full   (buf_full),
    .soi_ok     (soi_ok)
  );

endmodule

// File: rtl/cfc_checker.sv
module cfc_checker #(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] byte_count,
  input logic          buf_full,
  input logic          soi_ok
);

  assert_we_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(busy));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_count <= CW'(DEPTH));

  assert_full_gives_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> done);

  assert_addr_tracks_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == AW'(byte_count - 1'b1)));

  assert_soi_needs_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soi_ok |-> (byte_count >= CW'(2)));

endmodule

bind cam_frame_capture cfc_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .busy       (busy),
  .done       (done),
  .byte_count (byte_count),
  .buf_full   (buf_full),
  .soi_ok     (soi_ok)
);

// File: tb/cam_frame_capture_tb.sv
module cam_frame_capture_tb;

  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          arm;
  logic          cam_pclk, cam_vsync, cam_href;
  logic [7:0]    cam_data;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          busy, done, buf_full, soi_ok;
  logic [CW-1:0] byte_count;

  always #2.5 clk = ~clk;

  cam_frame_capture #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cam_pclk(cam_pclk),
    .cam_vsync(cam_vsync), .cam_href(cam_href), .cam_data(cam_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done), .byte_count(byte_count),
    .buf_full(buf_full), .soi_ok(soi_ok)
  );

  int n_vec  = 0;
  int n_fail = 0;
  int wr_seen = 0;
  int done_seen = 0;
  bit finished = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: input history queue and frame-level state.
  typedef struct { int vs; int hr; int pc; int d; } smp_t;
  smp_t hist[$];
  int m_state, m_gate, m_cnt, m_we, m_addr, m_wd, m_done, m_full, m_b0, m_b1;

  function automatic void model_reset();
    smp_t z = '{0, 0, 0, 0};
    hist = {};
    for (int i = 0; i < 4; i++) hist.push_back(z);
    m_state = 0; m_gate = 0; m_cnt = 0; m_we = 0; m_addr = 0;
    m_wd = 0; m_done = 0; m_full = 0; m_b0 = 0; m_b1 = 0;
  endfunction

  function automatic void model_step(input smp_t cur);
    smp_t s, p;
    int vr, vf, hrr, hf, pf;
    int ns, ng;
    hist.push_front(cur);
    void'(hist.pop_back());
    s = hist[2];
    p = hist[3];
    vr  = s.vs & ~p.vs & 1;
    vf  = ~s.vs & p.vs & 1;
    hrr = s.hr & ~p.hr & 1;
    hf  = ~s.hr & p.hr & 1;
    pf  = ~s.pc & p.pc & 1;
    ns = m_state; ng = m_gate;
    m_we = 0; m_done = 0;
    if (m_state == 0) begin
      if (vr && arm_q) begin
        ns = 1; ng = 1; m_cnt = 0; m_full = 0; m_b0 = 0; m_b1 = 0;
      end
    end else if (m_state == 1) begin
      if (hrr) ng = 1;
      if (hf) ng = 0;
      if (pf && m_gate) begin
        m_we = 1; m_addr = m_cnt; m_wd = s.d;
        if (m_cnt == 0) m_b0 = (s.d == 8'hFF);
        if (m_cnt == 1) m_b1 = (s.d == 8'hD8);
        m_cnt++;
        if (m_cnt == DEPTH) begin m_full = 1; m_done = 1; ns = 2; end
      end
      if (vf && ns == 1) begin m_done = 1; ns = 2; end
      if (ns != 1) ng = 0;
    end else begin
      if (!arm_q) ns = 0;
    end
    m_state = ns; m_gate = ng;
  endfunction

  logic arm_q;
  assign arm_q = arm;

  always @(negedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      smp_t cur;
      cur.vs = int'(cam_vsync); cur.hr = int'(cam_href);
      cur.pc = int'(cam_pclk);  cur.d  = int'(cam_data);
      model_step(cur);
      check("R1", "mem_we",     int'(mem_we),     m_we);
      check("R1", "mem_wdata",  int'(mem_wdata),  m_wd);
      check("R8", "mem_addr",   int'(mem_addr),   m_addr);
      check("R2", "busy",       int'(busy),       int'(m_state == 1));
      check("R5", "done",       int'(done),       m_done);
      check("R8", "byte_count", int'(byte_count), m_cnt);
      check("R6", "buf_full",   int'(buf_full),   m_full);
      check("R7", "soi_ok",     int'(soi_ok),     m_b0 & m_b1);
      if (mem_we) wr_seen++;
      if (done) done_seen++;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic pixel(input logic [7:0] b);
    cam_pclk = 1'b1; cam_data = b;
    wait_cyc(3);
    cam_pclk = 1'b0;
    wait_cyc(3);
  endtask

  task automatic rearm();
    arm = 1'b0; wait_cyc(3);
    arm = 1'b1; wait_cyc(3);
  endtask

  int w0, d0;

  initial begin
    rst_n = 1'b0; arm = 1'b0; cam_pclk = 1'b0; cam_vsync = 1'b0;
    cam_href = 1'b0; cam_data = 8'h00;
    wait_cyc(4);
    // R11 reset state
    check("R11", "reset busy",  int'(busy), 0);
    check("R11", "reset done",  int'(done), 0);
    check("R11", "reset count", int'(byte_count), 0);
    check("R11", "reset full",  int'(buf_full), 0);
    check("R11", "reset soi",   int'(soi_ok), 0);
    check("R11", "reset we",    int'(mem_we), 0);
    rst_n = 1'b1;
    wait_cyc(4);

    // R9: frame with arm low is ignored
    w0 = wr_seen;
    cam_vsync = 1'b1; wait_cyc(4);
    cam_href = 1'b1; wait_cyc(4);
    pixel(8'hFF); pixel(8'hD8); pixel(8'h11);
    cam_href = 1'b0; wait_cyc(4);
    cam_vsync = 1'b0; wait_cyc(8);
    check("R9", "writes while unarmed", wr_seen - w0, 0);
    check("R9", "count while unarmed", int'(byte_count), 0);

    // R3/R4: leading bytes with href low, a gap in href
    arm = 1'b1; wait_cyc(2);
    w0 = wr_seen; d0 = done_seen;
    cam_vsync = 1'b1; wait_cyc(6);
    pixel(8'hAA); pixel(8'hBB);
    cam_href = 1'b1; wait_cyc(4);
    pixel(8'hFF); pixel(8'hD8); pixel(8'h01); pixel(8'h02);
    cam_href = 1'b0; wait_cyc(4);
    pixel(8'h55); pixel(8'h66);
    cam_href = 1'b1; wait_cyc(4);
    pixel(8'h03);
    cam_href = 1'b0; wait_cyc(4);
    cam_vsync = 1'b0; wait_cyc(8);
    check("R3", "leading plus gated bytes", int'(byte_count), 7);
    check("R4", "writes with href gap", wr_seen - w0, 7);
    check("R7", "soi displaced by lead bytes", int'(soi_ok), 0);
    check("R5", "one done per frame", done_seen - d0, 1);

    // R10: arm still high, next frame ignored
    w0 = wr_seen;
    cam_vsync = 1'b1; wait_cyc(4);
    cam_href = 1'b1; wait_cyc(4);
    pixel(8'h77); pixel(8'h88);
    cam_href = 1'b0; wait_cyc(4);
    cam_vsync = 1'b0; wait_cyc(8);
    check("R10", "no writes without re-arm", wr_seen - w0, 0);
    check("R10", "count kept", int'(byte_count), 7);

    // R7: good start-of-image after re-arm
    rearm();
    w0 = wr_seen;
    cam_vsync = 1'b1; cam_href = 1'b1; wait_cyc(6);
    pixel(8'hFF); pixel(8'hD8); pixel(8'hFF); pixel(8'hE0); pixel(8'h10);
    cam_href = 1'b0; wait_cyc(4);
    cam_vsync = 1'b0; wait_cyc(8);
    check("R7", "soi good", int'(soi_ok), 1);
    check("R8", "count good frame", int'(byte_count), 5);
    check("R2", "rearmed frame stored", wr_seen - w0, 5);

    // R6: overrun stops at DEPTH
    rearm();
    w0 = wr_seen; d0 = done_seen;
    cam_vsync = 1'b1; cam_href = 1'b1; wait_cyc(6);
    pixel(8'hFF); pixel(8'hD8);
    for (int i = 0; i < DEPTH + 4; i++) pixel(8'(i + 8'h20));
    cam_href = 1'b0; wait_cyc(4);
    cam_vsync = 1'b0; wait_cyc(8);
    check("R6", "full flag", int'(buf_full), 1);
    check("R6", "count at depth", int'(byte_count), DEPTH);
    check("R6", "writes capped", wr_seen - w0, DEPTH);
    check("R6", "single done", done_seen - d0, 1);
    check("R7", "soi after overrun", int'(soi_ok), 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule